// File: doc/BRIEF.md
# Alternate-Space Identifier Resolver and Checker

This block sits in the decode path of a processor that supports memory instructions with an explicit address-space identifier (ASI). For each instruction word it chooses the 8-bit ASI, from either the instruction itself or the current ASI register, and attaches it to a 64-bit extended instruction word. It then classifies the ASI as little-endian, block-transfer or as-if-user, and decides whether the access has to be stopped. An access is stopped with a privileged-action fault or with a bad-ASI (data-access) fault. All of this happens before any address is generated or any memory is touched.

All results are registered, so every output reflects the inputs from the clock edge before. The fault decision is held in a verdict state register with three states: `VD_CLEAR` (no fault), `VD_PRIV` (privileged-action fault) and `VD_BAD_ASI` (illegal ASI for the opcode class). Reset forces `VD_CLEAR`. Each clock edge moves the register from any state to the verdict computed from the current inputs: `VD_PRIV` when the privilege rule trips, else `VD_BAD_ASI` when the legality rule trips, else `VD_CLEAR`.

The opcode class input uses this encoding:
- 0: plain access
- 1: generic alternate-space access
- 2: double-precision floating-point alternate load
- 3: reserved, handled exactly as class 1

Top module: `asi_resolver`

## Requirements
- R1: When instruction bit 13 is 1, `asi_o` equals the ASI register input that was sampled at the previous clock edge.
- R2: When instruction bit 13 is 0, `asi_o` equals instruction bits 12:5 that were sampled at the previous clock edge.
- R3: `ext_insn_o` holds the sampled instruction in bits 31:0 and the chosen ASI in bits 39:32. Bits 63:40 are zero.
- R4: For classes 1, 2 and 3, `priv_fault_o` is 1 when the privileged-mode input is 0 and ASI bit 7 is 0.
- R5: `as_if_user_o` is 1 exactly for ASIs 0x10, 0x11, 0x16, 0x17, 0x18, 0x19, 0x1E and 0x1F. For classes 1 to 3, such an ASI in non-privileged mode raises `priv_fault_o`.
- R6: For class 2, the legal ASIs are 0x04, 0x0C, 0x10, 0x11, 0x14–0x19, 0x1C–0x1F, 0x80–0x83, 0x88–0x8B, 0xD0–0xD3, 0xD8–0xDB, 0xF0, 0xF1, 0xF8 and 0xF9. Any other ASI raises `bad_asi_fault_o`. Classes 0, 1 and 3 never raise `bad_asi_fault_o`.
- R7: `block_o` is 1 exactly for ASIs 0x16, 0x17, 0x1E, 0x1F, 0xF0, 0xF1, 0xF8 and 0xF9.
- R8: `little_o` is 1 exactly when the ASI is in the legal list of R6 and ASI bit 3 is 1.
- R9: A privileged-action fault takes priority over a bad-ASI fault. The two fault outputs are never 1 in the same cycle.
- R10: Class 0 never raises a fault, whatever the ASI or privilege mode.
- R11: While reset is asserted and until the first clock edge after its release, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| insn_i | input | 32 | Instruction word |
| asi_reg_i | input | 8 | Current ASI register value |
| priv_mode_i | input | 1 | Privileged-mode bit of the processor state |
| op_class_i | input | 2 | Opcode class: 0 plain, 1 alternate, 2 double-FP alternate load, 3 as 1 |
| ext_insn_o | output | 64 | Extended instruction word with the ASI attached |
| asi_o | output | 8 | Chosen ASI |
| little_o | output | 1 | Little-endian ASI |
| block_o | output | 1 | Block-transfer ASI |
| as_if_user_o | output | 1 | As-if-user ASI |
| priv_fault_o | output | 1 | Privileged-action fault |
| bad_asi_fault_o | output | 1 | ASI illegal for the opcode class |

## Verification
The bench targets the following corner cases:
- **Illegal ASI in user mode.** A design that lets the legality check override the privilege check would raise both faults, or only the bad-ASI fault.
- **As-if-user and block codes in privileged mode.** These must pass without a fault while their flags are still set. A wrong table shows up as a spurious fault or a missing flag.
- **Bit-3 codes outside the legal list.** A design that derives little-endian from bit 3 alone would flag them.
- **Immediate-bit selection under random values.** Flipping the choice between the ASI register and the instruction field would change the ASI in both `asi_o` and the extended word.
- **Reserved class 3 and plain class 0.** These catch a class decode that is off by one.

// File: rtl/asi_chk_pkg.sv
package asi_chk_pkg;

    typedef enum logic [1:0] {
        CLS_PLAIN    = 2'd0,
        CLS_ALT      = 2'd1,
        CLS_DFP_LOAD = 2'd2,
        CLS_ALT_RSV  = 2'd3
    } op_class_e;

    typedef enum logic [1:0] {
        VD_CLEAR   = 2'd0,
        VD_PRIV    = 2'd1,
        VD_BAD_ASI = 2'd2
    } verdict_e;

    typedef struct packed {
        logic legal;
        logic little;
        logic block;
        logic as_if_user;
    } asi_attr_t;

endpackage

// File: rtl/asi_source_sel.sv
module asi_source_sel #(
    parameter int INSN_W   = 32,
    parameter int ASI_W    = 8,
    parameter int IMM_BIT  = 13,
    parameter int FIELD_LO = 5,
    parameter int EXT_W    = 64
) (
    input  logic [INSN_W-1:0] insn,
    input  logic [ASI_W-1:0]  asi_reg,
    output logic [ASI_W-1:0]  asi,
    output logic [EXT_W-1:0]  ext_insn
);
    localparam int FIELD_HI = FIELD_LO + ASI_W - 1;
    localparam int PAD_W    = EXT_W - INSN_W - ASI_W;

    always_comb begin
        if (insn[IMM_BIT]) asi = asi_reg;
        else               asi = insn[FIELD_HI:FIELD_LO];
        ext_insn = {{PAD_W{1'b0}}, asi, insn};
    end
endmodule

// File: rtl/asi_attr_decode.sv
module asi_attr_decode
    import asi_chk_pkg::*;
#(
    parameter int ASI_W = 8
) (
    input  logic [ASI_W-1:0] asi,
    output asi_attr_t        attr
);
    localparam int ENDIAN_BIT = 3;

    logic legal, blk, aiu;

    always_comb begin
        unique case (asi) inside
            8'h04, 8'h0C, 8'h10, 8'h11, [8'h14:8'h19], [8'h1C:8'h1F],
            [8'h80:8'h83], [8'h88:8'h8B], [8'hD0:8'hD3], [8'hD8:8'hDB],
            8'hF0, 8'hF1, 8'hF8, 8'hF9: legal = 1'b1;
            default:                    legal = 1'b0;
        endcase
        unique case (asi) inside
            8'h16, 8'h17, 8'h1E, 8'h1F, 8'hF0, 8'hF1, 8'hF8, 8'hF9: blk = 1'b1;
            default:                                                blk = 1'b0;
        endcase
        unique case (asi) inside
            8'h10, 8'h11, 8'h16, 8'h17, 8'h18, 8'h19, 8'h1E, 8'h1F: aiu = 1'b1;
            default:                                                aiu = 1'b0;
        endcase
        attr.legal      = legal;
        attr.little     = legal & asi[ENDIAN_BIT];
        attr.block      = blk;
        attr.as_if_user = aiu;
    end
endmodule

// File: rtl/asi_fault_arbiter.sv
module asi_fault_arbiter
    import asi_chk_pkg::*;
(
    input  op_class_e op_class,
    input  logic      priv_mode,
    input  logic      asi_msb,
    input  logic      legal,
    input  logic      as_if_user,
    output verdict_e  verdict
);
    logic priv_trip, legal_trip;

    always_comb begin
        priv_trip  = 1'b0;
        legal_trip = 1'b0;
        unique case (op_class)
            CLS_PLAIN: begin
                priv_trip  = 1'b0;
                legal_trip = 1'b0;
            end
            CLS_ALT, CLS_ALT_RSV: begin
                priv_trip  = !priv_mode && (!asi_msb || as_if_user);
            end
            CLS_DFP_LOAD: begin
                priv_trip  = !priv_mode && (!asi_msb || as_if_user);
                legal_trip = !legal;
            end
        endcase
        if (priv_trip)       verdict = VD_PRIV;
        else if (legal_trip) verdict = VD_BAD_ASI;
        else                 verdict = VD_CLEAR;
    end
endmodule

// File: rtl/asi_resolver.sv
module asi_resolver
    import asi_chk_pkg::*;
#(
    parameter int INSN_W   = 32,
    parameter int ASI_W    = 8,
    parameter int IMM_BIT  = 13,
    parameter int FIELD_LO = 5,
    parameter int EXT_W    = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [INSN_W-1:0] insn_i,
    input  logic [ASI_W-1:0]  asi_reg_i,
    input  logic              priv_mode_i,
    input  logic [1:0]        op_class_i,
    output logic [EXT_W-1:0]  ext_insn_o,
    output logic [ASI_W-1:0]  asi_o,
    output logic              little_o,
    output logic              block_o,
    output logic              as_if_user_o,
    output logic              priv_fault_o,
    output logic              bad_asi_fault_o
);
    localparam int MSB = ASI_W - 1;

    logic [ASI_W-1:0] asi_d;
    logic [EXT_W-1:0] ext_d;
    asi_attr_t        attr_d;
    verdict_e         verdict_d;

    logic [ASI_W-1:0] asi_q;
    logic [EXT_W-1:0] ext_q;
    asi_attr_t        attr_q;
    verdict_e         state_q;

    asi_source_sel #(
        .INSN_W(INSN_W), .ASI_W(ASI_W), .IMM_BIT(IMM_BIT),
        .FIELD_LO(FIELD_LO), .EXT_W(EXT_W)
    ) sel_i (
        .insn(insn_i), .asi_reg(asi_reg_i), .asi(asi_d), .ext_insn(ext_d)
    );

    asi_attr_decode #(.ASI_W(ASI_W)) dec_i (.asi(asi_d), .attr(attr_d));

    asi_fault_arbiter arb_i (
        .op_class(op_class_e'(op_class_i)),
        .priv_mode(priv_mode_i),
        .asi_msb(asi_d[MSB]),
        .legal(attr_d.legal),
        .as_if_user(attr_d.as_if_user),
        .verdict(verdict_d)
    );

    // Verdict state register plus the captured ASI data.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= VD_CLEAR;
            asi_q   <= '0;
            ext_q   <= '0;
            attr_q  <= '0;
        end else begin
            state_q <= verdict_d;
            asi_q   <= asi_d;
            ext_q   <= ext_d;
            attr_q  <= attr_d;
        end
    end

    // Output decode from the verdict state.
    always_comb begin
        ext_insn_o   = ext_q;
        asi_o        = asi_q;
        little_o     = attr_q.little;
        block_o      = attr_q.block;
        as_if_user_o = attr_q.as_if_user;
        unique case (state_q)
            VD_PRIV:    begin priv_fault_o = 1'b1; bad_asi_fault_o = 1'b0; end
            VD_BAD_ASI: begin priv_fault_o = 1'b0; bad_asi_fault_o = 1'b1; end
            default:    begin priv_fault_o = 1'b0; bad_asi_fault_o = 1'b0; end
        endcase
    end
endmodule

// File: rtl/asi_resolver_chk.sv
module asi_resolver_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] insn_i,
    input logic [7:0]  asi_reg_i,
    input logic        priv_mode_i,
    input logic [1:0]  op_class_i,
    input logic [63:0] ext_insn_o,
    input logic [7:0]  asi_o,
    input logic        little_o,
    input logic        block_o,
    input logic        as_if_user_o,
    input logic        priv_fault_o,
    input logic        bad_asi_fault_o
);
    logic armed;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    AST_SRC_REG: assert property (@(posedge clk) disable iff (!rst_n)
        armed && $past(insn_i[13]) |-> asi_o == $past(asi_reg_i)); // R1
    AST_SRC_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
        armed && !$past(insn_i[13]) |-> asi_o == $past(insn_i[12:5])); // R2
    AST_EXT_LAYOUT: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> ext_insn_o == {24'h0, asi_o, $past(insn_i)}); // R3
    AST_USER_LOW_ASI: assert property (@(posedge clk) disable iff (!rst_n)
        armed && $past(op_class_i) != 2'd0 && !$past(priv_mode_i) && !asi_o[7]
        |-> priv_fault_o); // R4
    AST_AIU_USER: assert property (@(posedge clk) disable iff (!rst_n)
        armed && as_if_user_o && $past(op_class_i) != 2'd0 && !$past(priv_mode_i)
        |-> priv_fault_o); // R5
    AST_BADASI_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
        bad_asi_fault_o |-> armed && $past(op_class_i) == 2'd2); // R6
    AST_BLOCK_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        block_o |-> !bad_asi_fault_o); // R7
    AST_LITTLE_BIT3: assert property (@(posedge clk) disable iff (!rst_n)
        little_o |-> asi_o[3]); // R8
    AST_ONE_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        !(priv_fault_o && bad_asi_fault_o)); // R9
    AST_PLAIN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        armed && $past(op_class_i) == 2'd0 |-> !priv_fault_o && !bad_asi_fault_o); // R10

    always_comb begin
        if (!rst_n) begin
            AST_RESET_ZERO: assert (ext_insn_o == '0 && asi_o == '0 && !little_o
                && !block_o && !as_if_user_o && !priv_fault_o && !bad_asi_fault_o); // R11
        end
    end
endmodule

bind asi_resolver asi_resolver_chk chk_i (.*);

// File: tb/asi_resolver_tb_top.sv
module asi_resolver_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] insn_i = '0;
    logic [7:0]  asi_reg_i = '0;
    logic        priv_mode_i = 1'b0;
    logic [1:0]  op_class_i = '0;
    logic [63:0] ext_insn_o;
    logic [7:0]  asi_o;
    logic        little_o, block_o, as_if_user_o, priv_fault_o, bad_asi_fault_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    asi_resolver dut_i (.*);

    function automatic bit f_legal(input logic [7:0] a);
        return (a == 8'h04 || a == 8'h0C || a == 8'h10 || a == 8'h11 ||
                (a >= 8'h14 && a <= 8'h19) || (a >= 8'h1C && a <= 8'h1F) ||
                (a >= 8'h80 && a <= 8'h83) || (a >= 8'h88 && a <= 8'h8B) ||
                (a >= 8'hD0 && a <= 8'hD3) || (a >= 8'hD8 && a <= 8'hDB) ||
                a == 8'hF0 || a == 8'hF1 || a == 8'hF8 || a == 8'hF9);
    endfunction
    function automatic bit f_block(input logic [7:0] a);
        return (a == 8'h16 || a == 8'h17 || a == 8'h1E || a == 8'h1F ||
                a == 8'hF0 || a == 8'hF1 || a == 8'hF8 || a == 8'hF9);
    endfunction
    function automatic bit f_aiu(input logic [7:0] a);
        return (a == 8'h10 || a == 8'h11 || a == 8'h18 || a == 8'h19 ||
                a == 8'h16 || a == 8'h17 || a == 8'h1E || a == 8'h1F);
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    // Drive at a falling edge, check at the next falling edge.
    task automatic run_vec(input logic [31:0] insn, input logic [7:0] areg,
                           input logic pm, input logic [1:0] cls);
        logic [7:0] a;
        bit pf, bf;
        @(negedge clk);
        insn_i = insn; asi_reg_i = areg; priv_mode_i = pm; op_class_i = cls;
        a  = insn[13] ? areg : insn[12:5];
        pf = (cls != 2'd0) && !pm && (!a[7] || f_aiu(a));
        bf = (cls == 2'd2) && !f_legal(a) && !pf;
        @(negedge clk);
        check(insn[13] ? "R1" : "R2", 64'(asi_o), 64'(a));
        check("R3", ext_insn_o, {24'h0, a, insn});
        check("R5", 64'(as_if_user_o), 64'(f_aiu(a)));
        check("R7", 64'(block_o), 64'(f_block(a)));
        check("R8", 64'(little_o), 64'(f_legal(a) && a[3]));
        check(cls == 2'd0 ? "R10" : "R4", 64'(priv_fault_o), 64'(pf));
        check(pf ? "R9" : "R6", 64'(bad_asi_fault_o), 64'(bf));
    endtask

    function automatic logic [31:0] mk(input logic imm, input logic [7:0] a, input logic [31:0] r);
        logic [31:0] w;
        w = r;
        w[13] = imm;
        w[12:5] = a;
        return w;
    endfunction

    initial begin
        #(CLK_PERIOD * 200000);
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'h5A17);
        insn_i = 32'hFFFF_FFFF; asi_reg_i = 8'h16; op_class_i = 2'd2;
        repeat (3) @(negedge clk);
        // R11: outputs zero while reset is held.
        check("R11", ext_insn_o, 64'h0);
        check("R11", {59'h0, little_o, block_o, as_if_user_o, priv_fault_o, bad_asi_fault_o}, 64'h0);
        rst_n = 1'b1;
        // Directed corner cases.
        run_vec(mk(1'b1, 8'h00, 32'h1234_0000), 8'hF0, 1'b1, 2'd2); // R1 block primary
        run_vec(mk(1'b0, 8'hF8, 32'h0), 8'h04, 1'b1, 2'd2);         // R8 little block
        run_vec(mk(1'b0, 8'h04, 32'h0), 8'h00, 1'b0, 2'd1);         // R4
        run_vec(mk(1'b0, 8'h16, 32'h0), 8'h00, 1'b1, 2'd2);         // R5 privileged ok
        run_vec(mk(1'b0, 8'h1E, 32'h0), 8'h00, 1'b0, 2'd2);         // R5 user faults
        run_vec(mk(1'b0, 8'h20, 32'h0), 8'h00, 1'b1, 2'd2);         // R6 bad
        run_vec(mk(1'b0, 8'h20, 32'h0), 8'h00, 1'b0, 2'd2);         // R9 priority
        run_vec(mk(1'b0, 8'h84, 32'h0), 8'h00, 1'b1, 2'd2);         // R6 above 0x80
        run_vec(mk(1'b0, 8'h84, 32'h0), 8'h00, 1'b1, 2'd1);         // R6 generic never bad
        run_vec(mk(1'b0, 8'h8C, 32'h0), 8'h00, 1'b0, 2'd2);         // R8 bit3 but illegal
        run_vec(mk(1'b0, 8'h04, 32'h0), 8'hFF, 1'b0, 2'd0);         // R10
        run_vec(mk(1'b0, 8'h10, 32'h0), 8'h00, 1'b0, 2'd3);         // R4 reserved class
        run_vec(mk(1'b1, 8'hF0, 32'h0), 8'h05, 1'b1, 2'd2);         // R1 reg over field
        // Constrained random: ASIs biased toward the interesting ranges.
        for (int i = 0; i < 400; i++) begin
            logic [7:0] fa, ra;
            fa = 8'($urandom);
            ra = 8'($urandom);
            if (($urandom % 2) == 0) fa = {fa[7], 2'b00, fa[4:0]} | (fa[7] ? 8'h00 : 8'h00);
            if (($urandom % 3) == 0) ra = {2'b11, ra[5:0]};
            run_vec(mk(1'($urandom), fa, $urandom), ra, 1'($urandom), 2'($urandom));
        end
        finish_run();
    end
endmodule